// File: doc/BRIEF.md
# Four-Entry Shift-Stack Processor

This block is a small zero-address processor. Its operands are held in a four-deep stack of data registers, and entry 0 is the top of that stack. Every instruction is fetched through an instruction pointer, a memory address register, a memory data register and an instruction register. After the fetch, the instruction either moves a word between memory and the stack or adds the two top entries. The stack is a shift-register file with no pointer, so all entries move at once. A push moves every entry one place down. A pop moves every entry one place up and fills the bottom entry with zero.

Memory is external and returns read data combinationally from `mem_addr`, so a read completes in one cycle counted from the register that holds the address. Writes happen at the clock edge while `mem_we` is high. The whole stack is brought out on a flat port so that its contents can be observed at any time. Execution starts at address 0 after reset and runs until a halt word is decoded.

Top module: `stk_proc`

## Requirements
- R1: While reset is active, all stack entries read zero, `halted` is low and `mem_addr` is zero. After reset is released, the first instruction is fetched from address 0.
- R2: An instruction word holds the opcode in bits [15:12] and a 12-bit field in bits [11:0]. Opcode 2 pushes the field, zero-extended to 16 bits.
- R3: Opcode 1 pushes the memory word found at the address given by the field.
- R4: A push moves entry k to entry k+1 for every entry at the same time, puts the new value in entry 0, and discards the previous bottom entry.
- R5: Opcode 3 writes the previous entry 0 to memory at the field address in one single write cycle. It moves every entry up by one and sets the bottom entry to zero.
- R6: Opcode 4 ignores its field. Entry 0 becomes the 16-bit wrapped sum of the old entries 0 and 1, the old entries 2 and 3 move up into entries 1 and 2, and entry 3 becomes zero.
- R7: The program "push immediate 1, push immediate 2, add, pop to X" leaves 3 at X and all stack entries at zero.
- R8: Opcode 15 stops execution. `halted` rises and stays high, and after that the stack does not change and memory is not written again until reset.
- R9: Opcodes 0 and 5 through 14 leave both the stack and memory unchanged, and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_addr | output | 12 | Memory address (the address register) |
| mem_rdata | input | 16 | Memory read data for `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| stack_flat | output | 64 | Stack contents, entry k at bits [16k+15:16k], entry 0 is the top |
| halted | output | 1 | High once a halt word has been decoded |

## Verification
A wrong shift direction, a missing zero fill or a sum written into the wrong entry shows on `stack_flat` in the same cycle the stack updates. It also shows later, when a pop writes memory. A wrong data or address register setting shows up as a wrong value or a wrong location in the memory write about two cycles after the pop is decoded. Random programs are compared against a reference model written in the bench, both for the final stack and for every data word. A stack or control error therefore surfaces within one program of a few dozen instructions.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_PUSH  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_PUSHI = 4'h2;
  localparam logic [OPC_W-1:0] OPC_POP   = 4'h3;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'hF;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_PUSH,
    SH_POP,
    SH_SUM
  } shift_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FREAD,
    ST_DECODE,
    ST_EXEC,
    ST_LOAD,
    ST_PUSH,
    ST_POP,
    ST_WRITE,
    ST_ADD,
    ST_SHIFT,
    ST_HALT
  } state_e;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] sum_o
);

  assign sum_o = opa_i + opb_i;

endmodule

// File: rtl/stk_file.sv
module stk_file
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  shift_e                       op_i,
  input  logic [DATA_W-1:0]            push_data_i,
  input  logic [DATA_W-1:0]            sum_i,
  output logic [DEPTH-1:0][DATA_W-1:0] ent_o
);

  logic ent_en;
  assign ent_en = (op_i != SH_HOLD);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic [DATA_W-1:0] ent_d;
    logic [DATA_W-1:0] from_above;
    logic [DATA_W-1:0] from_below;

    if (i == 0) begin : g_top
      assign from_above = push_data_i;
    end else begin : g_mid
      assign from_above = ent_o[i-1];
    end

    if (i == DEPTH-1) begin : g_bot
      assign from_below = '0;
    end else begin : g_up
      assign from_below = ent_o[i+1];
    end

    always_comb begin
      case (op_i)
        SH_PUSH: ent_d = from_above;
        SH_POP:  ent_d = from_below;
        SH_SUM:  ent_d = (i == 1) ? sum_i : ent_q;
        default: ent_d = ent_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign ent_o[i] = ent_q;
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] top_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mdr_o,
  output shift_e            sh_op_o,
  output logic              halted_o
);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] ip_q, ip_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [DATA_W-1:0] mdr_q, mdr_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic              ip_en, mar_en, mdr_en, ir_en;

  logic [OPC_W-1:0]  ir_opc;
  logic [ADDR_W-1:0] ir_fld;

  assign ir_opc = ir_q[DATA_W-1 -: OPC_W];
  assign ir_fld = ir_q[ADDR_W-1:0];

  always_comb begin
    state_d  = state_q;
    ip_d     = ip_q;
    mar_d    = mar_q;
    mdr_d    = mdr_q;
    ir_d     = ir_q;
    ip_en    = 1'b0;
    mar_en   = 1'b0;
    mdr_en   = 1'b0;
    ir_en    = 1'b0;
    sh_op_o  = SH_HOLD;
    mem_we_o = 1'b0;
    case (state_q)
      ST_FETCH: begin
        mar_d   = ip_q;
        mar_en  = 1'b1;
        state_d = ST_FREAD;
      end
      ST_FREAD: begin
        mdr_d   = mem_rdata_i;
        mdr_en  = 1'b1;
        ip_d    = ip_q + 1'b1;
        ip_en   = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d    = mdr_q;
        ir_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        case (ir_opc)
          OPC_PUSH: begin
            mar_d   = ir_fld;
            mar_en  = 1'b1;
            state_d = ST_LOAD;
          end
          OPC_PUSHI: begin
            mdr_d   = {{OPC_W{1'b0}}, ir_fld};
            mdr_en  = 1'b1;
            state_d = ST_PUSH;
          end
          OPC_POP: begin
            mar_d   = ir_fld;
            mar_en  = 1'b1;
            state_d = ST_POP;
          end
          OPC_ADD:  state_d = ST_ADD;
          OPC_HALT: state_d = ST_HALT;
          default:  state_d = ST_FETCH;
        endcase
      end
      ST_LOAD: begin
        mdr_d   = mem_rdata_i;
        mdr_en  = 1'b1;
        state_d = ST_PUSH;
      end
      ST_PUSH: begin
        sh_op_o = SH_PUSH;
        state_d = ST_FETCH;
      end
      ST_POP: begin
        mdr_d   = top_i;
        mdr_en  = 1'b1;
        sh_op_o = SH_POP;
        state_d = ST_WRITE;
      end
      ST_WRITE: begin
        mem_we_o = 1'b1;
        state_d  = ST_FETCH;
      end
      ST_ADD: begin
        sh_op_o = SH_SUM;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        sh_op_o = SH_POP;
        state_d = ST_FETCH;
      end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ip_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ip_en)  ip_q  <= ip_d;
      if (mar_en) mar_q <= mar_d;
      if (mdr_en) mdr_q <= mdr_d;
      if (ir_en)  ir_q  <= ir_d;
    end
  end

  assign mem_addr_o = mar_q;
  assign mdr_o      = mdr_q;
  assign halted_o   = (state_q == ST_HALT);

endmodule

// File: rtl/stk_proc.sv
module stk_proc
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [DEPTH*DATA_W-1:0] stack_flat,
  output logic                    halted
);

  logic                         core_rst_n;
  shift_e                       sh_op;
  logic [DATA_W-1:0]            mdr;
  logic [DATA_W-1:0]            sum;
  logic [DEPTH-1:0][DATA_W-1:0] ent;

  stk_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (core_rst_n)
  );

  stk_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .mem_rdata_i (mem_rdata),
    .top_i       (ent[0]),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mdr_o       (mdr),
    .sh_op_o     (sh_op),
    .halted_o    (halted)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .opa_i (ent[0]),
    .opb_i (ent[1]),
    .sum_o (sum)
  );

  stk_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_file (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .op_i        (sh_op),
    .push_data_i (mdr),
    .sum_i       (sum),
    .ent_o       (ent)
  );

  assign mem_wdata  = mdr;
  assign stack_flat = ent;

endmodule

// File: rtl/stk_proc_chk.sv
module stk_proc_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mem_we,
  input logic [DATA_W-1:0]       mem_wdata,
  input logic [DEPTH*DATA_W-1:0] stack_flat,
  input logic                    halted
);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(stack_flat)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  // R5
  pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == $past(stack_flat[DATA_W-1:0])));

  // R5
  pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (stack_flat[DEPTH*DATA_W-1 -: DATA_W] == '0));

  // R5
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

endmodule

bind stk_proc stk_proc_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .stack_flat (stack_flat),
  .halted     (halted)
);

// File: tb/stk_proc_bench.sv
module stk_proc_bench;

  logic        clk;
  logic        rst_n;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [63:0] stack_flat;
  logic        halted;

  logic [15:0] mem   [256];
  logic [15:0] m_mem [256];
  logic [15:0] m_st  [4];
  int total;
  int fails;

  stk_proc u_stk_proc (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .stack_flat (stack_flat),
    .halted     (halted)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] f);
    return {op, f};
  endfunction

  function automatic logic [15:0] ent(int k);
    return stack_flat[k*16 +: 16];
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic m_push(logic [15:0] v);
    m_st[3] = m_st[2]; m_st[2] = m_st[1]; m_st[1] = m_st[0]; m_st[0] = v;
  endtask

  task automatic m_pop();
    m_st[0] = m_st[1]; m_st[1] = m_st[2]; m_st[2] = m_st[3]; m_st[3] = 16'h0;
  endtask

  task automatic model_exec();
    logic [11:0] pc;
    pc = '0;
    for (int k = 0; k < 256; k++) m_mem[k] = mem[k];
    for (int k = 0; k < 4; k++) m_st[k] = 16'h0;
    for (int step = 0; step < 1000; step++) begin
      logic [15:0] w;
      w = m_mem[pc[7:0]];
      pc = pc + 12'd1;
      if (w[15:12] == 4'hF) break;
      case (w[15:12])
        4'h1: m_push(m_mem[w[7:0]]);
        4'h2: m_push({4'h0, w[11:0]});
        4'h3: begin m_mem[w[7:0]] = m_st[0]; m_pop(); end
        4'h4: begin m_st[1] = m_st[0] + m_st[1]; m_pop(); end
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(string tag);
    logic [63:0] snap;
    int bad;
    model_exec();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4000 && !halted; c++) @(negedge clk);
    chk(halted, "R8", {tag, " halt reached"}, {63'h0, halted}, 64'h1);
    for (int k = 0; k < 4; k++)
      chk(ent(k) == m_st[k], tag, $sformatf("stack entry %0d", k), ent(k), m_st[k]);
    bad = -1;
    for (int k = 128; k < 256; k++) if (bad < 0 && mem[k] !== m_mem[k]) bad = k;
    chk(bad < 0, tag, $sformatf("data word %0d", bad), (bad < 0) ? 64'h0 : mem[bad],
        (bad < 0) ? 64'h0 : m_mem[bad]);
    // R8: nothing after the halt word executes
    snap = stack_flat;
    repeat (25) @(negedge clk);
    bad = -1;
    for (int k = 128; k < 256; k++) if (bad < 0 && mem[k] !== m_mem[k]) bad = k;
    chk(stack_flat == snap && halted && bad < 0, "R8", {tag, " quiet after halt"},
        stack_flat, snap);
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 256; k++) mem[k] = 16'h0;
  endtask

  initial begin
    int unsigned seed_v;
    total = 0;
    fails = 0;
    seed_v = $urandom(32'h5eed);
    rst_n = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stack_flat == 64'h0, "R1", "stack in reset", stack_flat, 64'h0);
    chk(!halted && mem_addr == 12'h0, "R1", "halted/addr in reset",
        {51'h0, halted, mem_addr}, 64'h0);

    // R7: 1 + 2 stored to X=200
    clear_mem();
    mem[0] = ins(4'h2, 12'd1); mem[1] = ins(4'h2, 12'd2);
    mem[2] = ins(4'h4, 12'h0); mem[3] = ins(4'h3, 12'd200); mem[4] = ins(4'hF, 12'h0);
    run_prog("R7");
    chk(mem[200] == 16'd3, "R7", "sum at X", mem[200], 16'd3);

    // R2 and R4: five immediates, top field all ones, oldest discarded
    clear_mem();
    mem[0] = ins(4'h2, 12'd1); mem[1] = ins(4'h2, 12'd2); mem[2] = ins(4'h2, 12'd3);
    mem[3] = ins(4'h2, 12'd4); mem[4] = ins(4'h2, 12'hFFF); mem[5] = ins(4'hF, 12'h0);
    run_prog("R4");
    chk(ent(0) == 16'h0FFF && ent(3) == 16'd2, "R2", "zero-extended top, bottom",
        {ent(0), ent(3)}, {16'h0FFF, 16'd2});

    // R3 and R6: memory push and wrapped add with deep shift-up
    clear_mem();
    mem[150] = 16'hFFFF; mem[151] = 16'hBEEF;
    mem[0] = ins(4'h2, 12'd7); mem[1] = ins(4'h1, 12'd151); mem[2] = ins(4'h1, 12'd150);
    mem[3] = ins(4'h2, 12'd3); mem[4] = ins(4'h4, 12'hABC); mem[5] = ins(4'hF, 12'h0);
    run_prog("R6");
    chk(ent(0) == 16'd2 && ent(1) == 16'hBEEF && ent(2) == 16'd7 && ent(3) == 16'h0,
        "R3", "push from memory and wrapped add", stack_flat,
        {16'h0, 16'd7, 16'hBEEF, 16'd2});

    // R5 and R9: undefined opcodes interleaved, pops fill with zero
    clear_mem();
    mem[0] = ins(4'h2, 12'd7); mem[1] = ins(4'h0, 12'h123); mem[2] = ins(4'h5, 12'hFFF);
    mem[3] = ins(4'hE, 12'd128); mem[4] = ins(4'h2, 12'd9); mem[5] = ins(4'h3, 12'd130);
    mem[6] = ins(4'h3, 12'd131); mem[7] = ins(4'h3, 12'd132); mem[8] = ins(4'hF, 12'h0);
    mem[9] = ins(4'h2, 12'd55); mem[10] = ins(4'h3, 12'd140);
    run_prog("R9");
    chk(mem[130] == 16'd9 && mem[131] == 16'd7 && mem[132] == 16'd0 && mem[128] == 16'd0,
        "R5", "pop order and zero fill", {mem[128], mem[130], mem[131], mem[132]},
        {16'd0, 16'd9, 16'd7, 16'd0});

    // random programs against the model (R2 R3 R4 R5 R6 R8 R9)
    for (int p = 0; p < 30; p++) begin
      clear_mem();
      for (int k = 128; k < 256; k++) mem[k] = 16'($urandom);
      for (int k = 0; k < 24; k++) begin
        int unsigned r;
        r = $urandom % 10;
        case (r)
          0, 1, 2: mem[k] = ins(4'h2, 12'($urandom));
          3, 4:    mem[k] = ins(4'h1, 12'(128 + $urandom % 128));
          5, 6:    mem[k] = ins(4'h4, 12'($urandom));
          7, 8:    mem[k] = ins(4'h3, 12'(128 + $urandom % 128));
          default: mem[k] = ins((($urandom % 2) == 0) ? 4'h0 : 4'(5 + $urandom % 10),
                                12'(128 + $urandom % 128));
        endcase
      end
      mem[24] = ins(4'hF, 12'h0);
      for (int k = 25; k < 40; k++) mem[k] = ins(4'h3, 12'(128 + $urandom % 128));
      run_prog("R6");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule